// File: doc/BRIEF.md
# Parameter-selected reset register

This block is a clocked register whose reset behaviour is fixed at elaboration through parameters rather than written out by hand in every process. One set of parameters decides the value the register takes under reset, whether reset is asynchronous or synchronous, whether it is active low or active high, and whether a reset input is honoured at all. The same parameter serves as the reset value and as the register's initial value, so the two cannot drift apart.

A clock-enable can be included or left out. The register's next value comes from one of two datapaths. In counter mode it is the current value plus one, wrapping at the top of its range. In data mode it is the value on the data input. The default build is an 8-bit wrap-around counter with an asynchronous, active-low reset and an enable.

To change the reset scheme of every copy in a design, change the parameters at the instances. None of the register logic needs editing.

Top module: `cfg_reset_reg`

## Requirements
- R1: Under reset the output equals the parameter `INIT_VAL`, for every reset style (for example 8'h11 when `INIT_VAL` is 17).
- R2: With default parameters the reset is asynchronous and active when `rst` is 0, and the reset value is 8'h00.
- R3: With `RST_SYNC`=1 an active reset changes `q` only at a rising clock edge, and at that edge it takes priority over `en`.
- R4: With `RST_ACT_HIGH`=1 the reset is active when `rst` is 1.
- R5: With `RST_PRESENT`=0 the `rst` input has no effect on `q`; the register keeps loading and holding as if reset were inactive.
- R6: In counter mode (`COUNTER`=1) with the enable high, `q` steps up by one on each rising edge, and 8'hFF is followed by 8'h00.
- R7: With `EN_PRESENT`=1 and `en` at 0, `q` keeps its value across clock edges while no reset is active.
- R8: In asynchronous mode `q` takes the reset value as soon as reset becomes active, without a clock edge, and reset wins over `en` and `d`.
- R9: In data mode (`COUNTER`=0) `q` loads `d` on each rising edge when enabled, or on every edge if `EN_PRESENT`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Reset, polarity and style set by parameters, ignored when no reset is configured |
| en | input | 1 | Clock enable, ignored when `EN_PRESENT`=0 |
| d | input | WIDTH | Data loaded in data mode |
| q | output | WIDTH | Register value |

## Verification
The embedded properties assume that `rst`, `en` and `d` are driven to known levels from the start. They also assume that any asynchronous reset pulse stays active across at least one rising edge, because the properties only look at `rst` at clock edges. The stimulus changes inputs only on the falling edge. Each reset assertion in asynchronous mode is held through the next rising edge. Before that edge the output is checked in the middle of the low phase, to catch the reset taking effect with no clock.

// File: rtl/cfg_reset_reg.sv
module cfg_reset_reg #(
  parameter int               WIDTH        = 8,
  parameter logic [WIDTH-1:0] INIT_VAL     = '0,
  parameter bit               RST_PRESENT  = 1'b1,
  parameter bit               RST_SYNC     = 1'b0,
  parameter bit               RST_ACT_HIGH = 1'b0,
  parameter bit               EN_PRESENT   = 1'b1,
  parameter bit               COUNTER      = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] nxt;
  logic             rst_on;
  logic             upd;

  assign rst_on = RST_PRESENT && (RST_ACT_HIGH ? rst : !rst);
  assign upd    = !EN_PRESENT || en;
  assign nxt    = !upd ? q_r : (COUNTER ? q_r + WIDTH'(1) : d);
  assign q      = q_r;

  generate
    if (!RST_PRESENT) begin : g_norst
      always_ff @(posedge clk) q_r <= nxt;
    end else if (RST_SYNC) begin : g_sync
      always_ff @(posedge clk)
        if (rst_on) q_r <= INIT_VAL;
        else        q_r <= nxt;
    end else if (RST_ACT_HIGH) begin : g_async_hi
      always_ff @(posedge clk or posedge rst)
        if (rst) q_r <= INIT_VAL;
        else     q_r <= nxt;
    end else begin : g_async_lo
      always_ff @(posedge clk or negedge rst)
        if (!rst) q_r <= INIT_VAL;
        else      q_r <= nxt;
    end
  endgenerate

  // R8
  async_rst_chk: assert property (@(posedge clk)
    (RST_PRESENT && !RST_SYNC && rst_on) |-> q == INIT_VAL);

  // R3
  sync_rst_chk: assert property (@(posedge clk)
    (RST_PRESENT && RST_SYNC && rst_on) |=> q == INIT_VAL);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst_on)
    (EN_PRESENT && !en) |=> $stable(q));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (rst_on)
    (COUNTER && (!EN_PRESENT || en)) |=> q == WIDTH'($past(q) + 1'b1));

  // R9
  load_chk: assert property (@(posedge clk) disable iff (rst_on)
    (!COUNTER && (!EN_PRESENT || en)) |=> q == $past(d));

endmodule

// File: tb/cfg_reset_reg_tb.sv
`timescale 1ns/1ps
module cfg_reset_reg_tb_top;
  logic clk = 1'b0;
  logic rst_req, en;
  logic [7:0] d;
  logic rst_n, rst_h;
  logic [7:0] q_a, q_s, q_n, q_d;
  logic [7:0] ea, es, e_n, ed;
  int total = 0, bad = 0;
  bit done = 0;

  assign rst_n = ~rst_req;
  assign rst_h = rst_req;

  always #2.5 clk = ~clk;

  cfg_reset_reg dut_i (.clk(clk), .rst(rst_n), .en(en), .d(d), .q(q_a));
  cfg_reset_reg #(.INIT_VAL(8'd17), .RST_SYNC(1'b1), .RST_ACT_HIGH(1'b1))
    sync_i (.clk(clk), .rst(rst_h), .en(en), .d(d), .q(q_s));
  cfg_reset_reg #(.RST_PRESENT(1'b0), .COUNTER(1'b0))
    nores_i (.clk(clk), .rst(rst_n), .en(en), .d(d), .q(q_n));
  cfg_reset_reg #(.INIT_VAL(8'hA5), .RST_ACT_HIGH(1'b1), .EN_PRESENT(1'b0), .COUNTER(1'b0))
    dreg_i (.clk(clk), .rst(rst_h), .en(en), .d(d), .q(q_d));

  function automatic logic [7:0] model(logic [7:0] cur, bit ract, bit has_en, bit cnt,
                                       logic e, logic [7:0] din, logic [7:0] init);
    if (ract) return init;
    if (has_en && !e) return cur;
    return cnt ? cur + 8'd1 : din;
  endfunction

  task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk); #1;
    ea  = model(ea,  rst_req, 1, 1, en, d, 8'h00);
    es  = model(es,  rst_req, 1, 1, en, d, 8'd17);
    e_n = model(e_n, 1'b0,    1, 0, en, d, 8'h00);
    ed  = model(ed,  rst_req, 0, 0, en, d, 8'hA5);
    check(q_a, ea,  "R6 default counter");
    check(q_s, es,  "R3 sync high counter");
    check(q_n, e_n, "R5 no-reset data reg");
    check(q_d, ed,  "R9 async high data reg");
    @(negedge clk);
  endtask

  // assert reset mid low phase, check async effect before the edge
  task automatic async_probe(logic e, logic [7:0] din);
    en = e; d = din; rst_req = 1'b1;
    #1;
    check(q_a, 8'h00, "R8 async low reset without clock");
    check(q_d, 8'hA5, "R4 async high reset without clock");
    check(q_s, es,    "R3 sync reset waits for edge");
    check(q_n, e_n,   "R5 reset ignored");
    ea = 8'h00; ed = 8'hA5;
    cycle();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_req = 1'b1; en = 1'b1; d = 8'h3C;
    ea = 0; es = 0; e_n = 0; ed = 0;
    #1;
    check(q_a, 8'h00, "R2 default async low reset state");
    check(q_d, 8'hA5, "R1 reset equals init value");
    @(negedge clk);
    cycle();
    check(q_s, 8'd17, "R1 sync reset value equals init");
    check(q_n, 8'h3C, "R5 loads while reset asserted");
    d = 8'h5A; cycle();

    rst_req = 1'b0; en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      d = 8'(i * 37 + 1);
      cycle();
      check(q_a, 8'h00, "R7 hold with enable low");
      check(q_n, 8'h5A, "R7 data reg hold with enable low");
    end

    en = 1'b1;
    for (int i = 0; i < 255; i++) begin d = 8'(i); cycle(); end
    check(q_a, 8'hFF, "R6 counter reaches FF");
    cycle();
    check(q_a, 8'h00, "R6 counter wraps to 00");

    rst_req = 1'b1; en = 1'b1; cycle();
    check(q_s, 8'd17, "R3 sync reset beats enable");
    rst_req = 1'b0; cycle();

    async_probe(1'b1, 8'hC3);
    rst_req = 1'b0; cycle();

    for (int i = 0; i < 600; i++) begin
      if ($urandom % 12 == 0) begin
        async_probe(1'($urandom), 8'($urandom));
      end else begin
        rst_req = ($urandom % 10 == 0);
        en = ($urandom % 10 < 7);
        d = 8'($urandom);
        cycle();
      end
    end
    rst_req = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule